// File: doc/BRIEF.md
# Two-Wire Word Register Slave

This block is a two-wire serial slave that gives a bus master access to a small bank of 16-bit registers. It samples the clock and data lines with the system clock through a short synchronizer and recognises start, repeated start and stop conditions. Every access names a register through a command byte (the register pointer). Every data transfer is one word, sent as two bytes with the high byte first.

The bank has four registers. Pointer 0 holds a sensor reading. Internal logic loads it, and the bus can only read it. Pointer 1 holds control bits, pointer 2 an upper limit and pointer 3 a lower limit. Internal logic reads these three on dedicated outputs. The slave address is the fixed prefix 0011 followed by three strap inputs. The slave drives the data line only by pulling it low, so `sda_pull` is meant to enable an open-drain driver.

Top module: `i2cw_slave`

## Requirements
- R1: Out of reset, `sda_pull` is 0, `ctrl_word` is 0x0000, `limit_hi` is 0x0550, `limit_lo` is 0x0000 and the sensor register reads 0x0000.
- R2: The slave answers the address byte {0011, dev_strap[2:0], rw}, sent MSB first, by holding `sda_pull` high during the ninth clock. It also acknowledges the command byte and every accepted write data byte. It changes `sda_pull` only while SCL is low.
- R3: After an address byte that does not match, the slave does not acknowledge that byte or any byte after it, and no register changes until the next start.
- R4: A word write is: start, address with rw=0, command byte, high data byte, low data byte, stop. It loads {high, low} into the register the pointer selects (1 = `ctrl_word`, 2 = `limit_hi`, 3 = `limit_lo`).
- R5: If a stop follows the first data byte of a write, the partial word is discarded and the target register is unchanged.
- R6: A write whose pointer is 0 or 4 and above has its high data byte left unacknowledged, and no register changes.
- R7: A word read is: start, address with rw=0, command byte, repeated start, address with rw=1. The slave then returns the high byte and then the low byte of the selected register, each MSB first, driving each bit while SCL is low.
- R8: A one-cycle `sens_load` pulse stores `sens_value` in register 0, and a bus read of pointer 0 returns it.
- R9: The word being read is captured at the start of its high byte. A sensor load between the two bytes does not change the low byte returned, and the next read returns the new value.
- R10: Once the master does not acknowledge the low byte, the slave leaves SDA released until the next start, including during any further clocks.
- R11: A read of a pointer of 4 or above returns 0x0000.
- R12: The pointer persists between transactions. A read that starts directly with the address with rw=1 returns the register the last command byte selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_strap | input | 3 | Low three bits of the slave address |
| sens_load | input | 1 | Load strobe for the sensor register |
| sens_value | input | 16 | New sensor value |
| ctrl_word | output | 16 | Control register (pointer 1) |
| limit_hi | output | 16 | Upper limit register (pointer 2) |
| limit_lo | output | 16 | Lower limit register (pointer 3) |

## Verification
The hardest case to reach is a sensor update that lands between the two bytes of a read, because it has to fall inside one narrow window of the bus transfer. The bench reaches it by making its read task load a new sensor value at the point where the master has acknowledged the high byte and has not yet clocked the low byte. It then checks that the word it receives is whole and that the next read returns the new value. Partial writes, writes to read-only or missing pointers and foreign addresses are driven as directed cases. Random writes and read-backs against a bench model, with occasional sensor loads mixed in, cover the rest.

// File: rtl/i2cw_pkg.sv
// Shared constants and the transfer state type of the word register slave.
package i2cw_pkg;
    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
        ST_WHI, ST_WHI_ACK, ST_WLO, ST_WLO_ACK,
        ST_RHI, ST_MACK_HI, ST_RLO, ST_MACK_LO, ST_SKIP
    } xfer_st_e;
endpackage

// File: rtl/i2cw_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and flags clock
// edges and start/stop conditions. Assumes SCL stays in each level for
// several system clocks.
module i2cw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_s, scl_d, sda_d;

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cw_regbank.sv
// Register bank: entry 0 is a read-only sensor word loaded from internal
// logic, and the other entries are written from the bus. Reads of pointers
// past the bank return zero.
module i2cw_regbank
    import i2cw_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_CTRL   = 16'h0000,
    parameter logic [DATA_W-1:0] RST_THR_HI = 16'h0550,
    parameter logic [DATA_W-1:0] RST_THR_LO = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sens_load,
    input  logic [DATA_W-1:0] sens_value,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] ptr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ptr_writable,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] limit_hi,
    output logic [DATA_W-1:0] limit_lo
);
    logic [NUM_REGS-1:0][DATA_W-1:0] reg_vec;
    logic ptr_in_bank;

    // Reset value of a writable register, chosen by its index.
    function automatic logic [DATA_W-1:0] rst_of(input int idx);
        case (idx)
            1:       return RST_CTRL;
            2:       return RST_THR_HI;
            default: return RST_THR_LO;
        endcase
    endfunction

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] q;
        if (i == 0) begin : g_ro
            // Sensor word: loaded only from internal logic.
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= '0;
                else if (sens_load) q <= sens_value;
            end
        end else begin : g_rw
            // Bus-writable word: loaded on a committed write to its pointer.
            always_ff @(posedge clk) begin
                if (!rst_n)                                  q <= rst_of(i);
                else if (wr_en && ptr == BYTE_W'(i))         q <= wr_data;
            end
        end
        assign reg_vec[i] = q;
    end

    assign ptr_in_bank  = (ptr < BYTE_W'(NUM_REGS));
    assign ptr_writable = ptr_in_bank && (ptr != '0);
    assign rd_data      = ptr_in_bank ? reg_vec[ptr[IDX_W-1:0]] : '0;
    assign ctrl_word    = reg_vec[1];
    assign limit_hi     = reg_vec[2];
    assign limit_lo     = reg_vec[3];
endmodule

// File: rtl/i2cw_xfer_fsm.sv
// Bus protocol engine: shifts bytes in on SCL rising edges, drives ACK and
// read data after SCL falling edges, and keeps the register pointer.
// Assumes SCL low lasts long enough for the synchronizer delay.
module i2cw_xfer_fsm
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [6:0]        dev_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              ptr_writable,
    output logic [BYTE_W-1:0] ptr_q,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sda_pull
);
    xfer_st_e          state_q;
    logic [3:0]        bit_cnt, tx_idx, tx_nxt;
    logic [BYTE_W-1:0] rx_q, hi_q;
    logic [DATA_W-1:0] shadow_q;
    logic              rnw_q, mack_q, oe_q, wr_en_q;
    logic [DATA_W-1:0] wr_data_q;

    assign tx_nxt = tx_idx + 4'd1;

    // Protocol sequencing; bus conditions take priority over bit events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt   <= '0;
            tx_idx    <= '0;
            rx_q      <= '0;
            hi_q      <= '0;
            ptr_q     <= '0;
            shadow_q  <= '0;
            rnw_q     <= 1'b0;
            mack_q    <= 1'b0;
            oe_q      <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_det) begin
                state_q <= ST_ADDR;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_CMD, ST_WHI, ST_WLO: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            rx_q    <= {rx_q[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            case (state_q)
                                ST_ADDR: begin
                                    if (rx_q[7:1] == dev_addr) begin
                                        oe_q    <= 1'b1;
                                        rnw_q   <= rx_q[0];
                                        state_q <= ST_ADDR_ACK;
                                    end else begin
                                        state_q <= ST_SKIP;
                                    end
                                end
                                ST_CMD: begin
                                    ptr_q   <= rx_q;
                                    oe_q    <= 1'b1;
                                    state_q <= ST_CMD_ACK;
                                end
                                ST_WHI: begin
                                    if (ptr_writable) begin
                                        hi_q    <= rx_q;
                                        oe_q    <= 1'b1;
                                        state_q <= ST_WHI_ACK;
                                    end else begin
                                        state_q <= ST_SKIP;
                                    end
                                end
                                default: begin
                                    wr_data_q <= {hi_q, rx_q};
                                    wr_en_q   <= 1'b1;
                                    oe_q      <= 1'b1;
                                    state_q   <= ST_WLO_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rnw_q) begin
                                shadow_q <= rd_data;
                                oe_q     <= ~rd_data[DATA_W-1];
                                tx_idx   <= '0;
                                state_q  <= ST_RHI;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK: if (scl_fall) begin oe_q <= 1'b0; state_q <= ST_WHI; end
                    ST_WHI_ACK: if (scl_fall) begin oe_q <= 1'b0; state_q <= ST_WLO; end
                    ST_WLO_ACK: if (scl_fall) begin oe_q <= 1'b0; state_q <= ST_SKIP; end
                    ST_RHI, ST_RLO: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                bit_cnt <= '0;
                                oe_q    <= 1'b0;
                                state_q <= (state_q == ST_RHI) ? ST_MACK_HI : ST_MACK_LO;
                            end else begin
                                tx_idx <= tx_nxt;
                                oe_q   <= ~shadow_q[4'd15 - tx_nxt];
                            end
                        end
                    end
                    ST_MACK_HI: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                tx_idx  <= tx_nxt;
                                oe_q    <= ~shadow_q[4'd15 - tx_nxt];
                                state_q <= ST_RLO;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_MACK_LO: if (scl_fall) state_q <= ST_SKIP;
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = oe_q;
    assign wr_en    = wr_en_q;
    assign wr_data  = wr_data_q;
endmodule

// File: rtl/i2cw_slave.sv
// Top of the word register slave: line synchronizer, protocol engine and
// register bank. The address is a fixed 4-bit prefix plus three straps.
module i2cw_slave
    import i2cw_pkg::*;
#(
    parameter logic [3:0]        ADDR_PREFIX = 4'b0011,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] RST_CTRL    = 16'h0000,
    parameter logic [DATA_W-1:0] RST_THR_HI  = 16'h0550,
    parameter logic [DATA_W-1:0] RST_THR_LO  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [2:0]        dev_strap,
    input  logic              sens_load,
    input  logic [DATA_W-1:0] sens_value,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] limit_hi,
    output logic [DATA_W-1:0] limit_lo
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, ptr_writable;
    logic [BYTE_W-1:0] ptr;
    logic [DATA_W-1:0] wr_data, rd_data;

    i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cw_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .dev_addr({ADDR_PREFIX, dev_strap}), .rd_data(rd_data),
        .ptr_writable(ptr_writable), .ptr_q(ptr), .wr_en(wr_en),
        .wr_data(wr_data), .sda_pull(sda_pull)
    );

    i2cw_regbank #(
        .RST_CTRL(RST_CTRL), .RST_THR_HI(RST_THR_HI), .RST_THR_LO(RST_THR_LO)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sens_load(sens_load), .sens_value(sens_value),
        .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data), .rd_data(rd_data),
        .ptr_writable(ptr_writable), .ctrl_word(ctrl_word),
        .limit_hi(limit_hi), .limit_lo(limit_lo)
    );
endmodule

// File: rtl/i2cw_slave_chk.sv
// Protocol checks on the slave, attached with bind. Assumes the signals
// named in the bind statement below.
module i2cw_slave_chk
    import i2cw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic [BYTE_W-1:0] ptr,
    input logic [DATA_W-1:0] ctrl_word,
    input logic [DATA_W-1:0] limit_hi
);
    // The slave starts pulling SDA only right after an SCL falling edge.
    p_pull_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // A start condition leaves SDA released.
    p_start_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull);

    // A stop condition leaves SDA released.
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // Commits only ever target a writable pointer.
    p_wr_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr != '0 && ptr < BYTE_W'(NUM_REGS)));

    // The control word changes only through a commit to pointer 1.
    p_ctrl_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word != $past(ctrl_word)) |-> ($past(wr_en) && $past(ptr) == 8'd1));

    // The upper limit changes only through a commit to pointer 2.
    p_limit_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_hi != $past(limit_hi)) |-> ($past(wr_en) && $past(ptr) == 8'd2));
endmodule

bind i2cw_slave i2cw_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en), .ptr(ptr),
    .ctrl_word(ctrl_word), .limit_hi(limit_hi)
);

// File: tb/sim_i2cw_slave.sv
`timescale 1ns/1ps
module sim_i2cw_slave;
    localparam int Q = 5;  // system clocks per quarter SCL period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic [2:0]  strap = 3'b101;
    logic        sens_load = 1'b0;
    logic [15:0] sens_value = '0;
    logic [15:0] ctrl_word, limit_hi, limit_lo;
    wire         sda_line = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] mdl [4];

    always #2.5 clk = ~clk;

    i2cw_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .dev_strap(strap), .sens_load(sens_load),
        .sens_value(sens_value), .ctrl_word(ctrl_word),
        .limit_hi(limit_hi), .limit_lo(limit_lo)
    );

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] my_addr();
        return {4'b0011, strap};
    endfunction

    function automatic bit writable(input logic [7:0] p);
        return (p >= 8'd1 && p <= 8'd3);
    endfunction

    function automatic logic [15:0] exp_read(input logic [7:0] p);
        return (p < 8'd4) ? mdl[p[1:0]] : 16'h0000;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        s = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    task automatic load_sensor(input logic [15:0] v);
        @(negedge clk);
        sens_value = v;
        sens_load  = 1'b1;
        @(negedge clk);
        sens_load  = 1'b0;
        mdl[0]     = v;
    endtask

    // Word write; 'full' = 0 stops after the high data byte.
    task automatic wr_word(input logic [6:0] a, input logic [7:0] p, input logic [15:0] d,
                           input bit full, output logic [3:0] acks);
        bus_start();
        put_byte({a, 1'b0}, acks[3]);
        put_byte(p, acks[2]);
        put_byte(d[15:8], acks[1]);
        if (full) put_byte(d[7:0], acks[0]);
        else acks[0] = 1'b0;
        bus_stop();
    endtask

    // Word read; optional command phase, optional sensor load between the
    // bytes, optional extra byte clocked after the final NACK.
    task automatic rd_word(input logic [6:0] a, input logic [7:0] p, input bit use_cmd,
                           input bit tear, input logic [15:0] tear_val,
                           output logic [15:0] d, output logic [7:0] extra,
                           output logic [2:0] acks);
        acks = '0;
        if (use_cmd) begin
            bus_start();
            put_byte({a, 1'b0}, acks[2]);
            put_byte(p, acks[1]);
        end
        bus_start();
        put_byte({a, 1'b1}, acks[0]);
        get_byte(1'b1, d[15:8]);
        if (tear) load_sensor(tear_val);
        get_byte(1'b0, d[7:0]);
        get_byte(1'b0, extra);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [3:0]  wa;
        logic [2:0]  ra;
        logic [15:0] rd;
        logic [7:0]  ex;
        int          seed;
        seed = $urandom(32'd4242);
        mdl[0] = 16'h0000; mdl[1] = 16'h0000; mdl[2] = 16'h0550; mdl[3] = 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 sda_pull", {15'd0, sda_pull}, 16'h0000);
        check("R1 ctrl_word", ctrl_word, 16'h0000);
        check("R1 limit_hi", limit_hi, 16'h0550);
        check("R1 limit_lo", limit_lo, 16'h0000);
        rd_word(my_addr(), 8'd0, 1'b1, 1'b0, '0, rd, ex, ra);
        check("R1 sensor reads zero", rd, 16'h0000);

        // R2 acknowledges + R4 word write
        wr_word(my_addr(), 8'd1, 16'hA5C3, 1'b1, wa);
        check("R2 write acks", {12'd0, wa}, 16'h000F);
        check("R4 ctrl_word written", ctrl_word, 16'hA5C3);
        mdl[1] = 16'hA5C3;
        wr_word(my_addr(), 8'd2, 16'h1E7F, 1'b1, wa);
        wr_word(my_addr(), 8'd3, 16'h8001, 1'b1, wa);
        mdl[2] = 16'h1E7F; mdl[3] = 16'h8001;
        check("R4 limit_hi written", limit_hi, 16'h1E7F);
        check("R4 limit_lo written", limit_lo, 16'h8001);

        // R2 straps select the address
        strap = 3'b010;
        wr_word(7'b0011010, 8'd1, 16'h0F0F, 1'b1, wa);
        check("R2 new strap acks", {12'd0, wa}, 16'h000F);
        check("R2 new strap write", ctrl_word, 16'h0F0F);
        mdl[1] = 16'h0F0F;
        strap = 3'b101;

        // R3 foreign addresses are ignored
        wr_word(7'b0011100, 8'd1, 16'h5555, 1'b1, wa);
        check("R3 strap mismatch acks", {12'd0, wa}, 16'h0000);
        check("R3 strap mismatch no write", ctrl_word, 16'h0F0F);
        wr_word({4'b1011, 3'b101}, 8'd2, 16'h6666, 1'b1, wa);
        check("R3 prefix mismatch acks", {12'd0, wa}, 16'h0000);
        check("R3 prefix mismatch no write", limit_hi, 16'h1E7F);

        // R5 partial write discarded
        wr_word(my_addr(), 8'd3, 16'h3C3C, 1'b0, wa);
        check("R5 partial acks", {12'd0, wa}, 16'h000E);
        check("R5 partial discarded", limit_lo, 16'h8001);

        // R8 sensor load and read
        load_sensor(16'h0BEE);
        rd_word(my_addr(), 8'd0, 1'b1, 1'b0, '0, rd, ex, ra);
        check("R8 sensor read", rd, 16'h0BEE);
        check("R7 read acks", {13'd0, ra}, 16'h0007);

        // R6 writes to read-only or missing pointers
        wr_word(my_addr(), 8'd0, 16'h1234, 1'b1, wa);
        check("R6 ro pointer acks", {12'd0, wa}, 16'h000C);
        rd_word(my_addr(), 8'd0, 1'b1, 1'b0, '0, rd, ex, ra);
        check("R6 sensor unchanged", rd, 16'h0BEE);
        wr_word(my_addr(), 8'd9, 16'h4321, 1'b1, wa);
        check("R6 missing pointer acks", {12'd0, wa}, 16'h000C);
        check("R6 ctrl unchanged", ctrl_word, 16'h0F0F);

        // R7 read of a writable register
        rd_word(my_addr(), 8'd2, 1'b1, 1'b0, '0, rd, ex, ra);
        check("R7 read limit_hi", rd, 16'h1E7F);

        // R9 sensor update between the bytes
        rd_word(my_addr(), 8'd0, 1'b1, 1'b1, 16'hFACE, rd, ex, ra);
        check("R9 no tearing", rd, 16'h0BEE);
        rd_word(my_addr(), 8'd0, 1'b1, 1'b0, '0, rd, ex, ra);
        check("R9 next read new value", rd, 16'hFACE);

        // R10 SDA released after the final NACK (extra byte reads all ones)
        rd_word(my_addr(), 8'd3, 1'b1, 1'b0, '0, rd, ex, ra);
        check("R10 released after NACK", {8'd0, ex}, 16'h00FF);
        check("R7 read limit_lo", rd, 16'h8001);

        // R11 pointer out of bank reads zero
        rd_word(my_addr(), 8'd6, 1'b1, 1'b0, '0, rd, ex, ra);
        check("R11 missing pointer reads zero", rd, 16'h0000);

        // R12 pointer retained across transactions
        rd_word(my_addr(), 8'd1, 1'b1, 1'b0, '0, rd, ex, ra);
        rd_word(my_addr(), 8'd0, 1'b0, 1'b0, '0, rd, ex, ra);
        check("R12 read without command", rd, 16'h0F0F);

        // Random writes and read-backs against the model (R4, R6, R7, R8)
        for (int it = 0; it < 25; it++) begin
            logic [7:0]  p;
            logic [15:0] d;
            p = 8'($urandom_range(0, 5));
            d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) load_sensor(16'($urandom));
            wr_word(my_addr(), p, d, 1'b1, wa);
            check("R6 random write acks", {12'd0, wa},
                  writable(p) ? 16'h000F : 16'h000C);
            if (writable(p)) mdl[p[1:0]] = d;
            rd_word(my_addr(), p, 1'b1, 1'b0, '0, rd, ex, ra);
            check("R7 random read-back", rd, exp_read(p));
        end
        check("R4 final ctrl_word", ctrl_word, mdl[1]);
        check("R4 final limit_hi", limit_hi, mdl[2]);
        check("R4 final limit_lo", limit_lo, mdl[3]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule